// File: doc/BRIEF.md
# Flash Bank Erase/Program Sequencer

This block runs a complete erase or a complete program of one bank of a byte-wide flash device. The device accepts a command only after two unlock writes at fixed offsets inside the bank. A one-cycle request selects the operation and the bank. The sequencer then issues every command write itself, separated by a programmable gap. Program data comes from a source that the block indexes by byte offset and that answers in the same cycle.

The flash reports that it has finished an internal operation by toggling a status bit on every read. The sequencer reads the bank base twice in a row and treats two equal reads as completion. A cap on the number of read pairs turns a stuck device into a timeout, and a timeout during programming abandons the bytes not yet written. Every operation ends with a reset write to the bank base. An operation that did not time out then reads back the whole bank and compares it with 0xFF after an erase, or with the source bytes after a program. The result is a one-cycle `done` pulse with a 2-bit status code.

States:
- `ST_IDLE`: waits for a request.
- `ST_CMD`: drives one command write.
- `ST_GAP`: the idle gap after a command write.
- `ST_POLL_A` and `ST_POLL_B`: the two reads of a completion pair.
- `ST_RST`: the reset write.
- `ST_RGAP`: the gap after the reset write.
- `ST_VERIFY`: the bank readback.
- `ST_DONE`: the result pulse.

Transitions:
- IDLE→CMD on a request.
- CMD→GAP always.
- GAP→CMD while the script has commands left.
- GAP→POLL_A after the last command of a script.
- POLL_A→POLL_B always.
- From POLL_B:
  - to POLL_A when the two reads differ and the pair limit has not been reached;
  - to RST when the two reads differ at the limit (timeout);
  - to GAP when the two reads match and more program bytes remain;
  - to RST when the two reads match on the final byte or after an erase.
- RST→RGAP always.
- RGAP→VERIFY, or RGAP→DONE after a timeout.
- VERIFY→DONE after the last offset.
- DONE→IDLE always.

Top module: `flsq_bank_seq`

## Requirements
- R1: An erase issues exactly six writes, in this order, all inside the selected bank (offset → data): KEY_A → 0xAA, KEY_B → 0x55, KEY_A → 0x80, KEY_A → 0xAA, KEY_B → 0x55, offset 0 → 0x30. KEY_A is 0x555 and KEY_B is 0x2AA, each truncated to the offset width.
- R2: A program walks the bank offsets in ascending order. For each offset it issues KEY_A → 0xAA, KEY_B → 0x55, KEY_A → 0xA0, and then the source byte for that offset written at that offset. `src_idx` presents the offset to the source.
- R3: Any two flash writes are separated by at least GAP cycles in which `fl_we` is low.
- R4: After each command script, the block reads offset 0 of the bank in pairs of back-to-back reads. It stops polling at the first pair whose two values are equal.
- R5: After POLL_LIMIT unequal pairs, the operation times out and reports status 2'b01. A program abandons its remaining bytes, and no readback is done.
- R6: Every operation, whether it succeeds or times out, writes 0xF0 to offset 0 of the bank before `done`.
- R7: Without a timeout, every offset of the bank is read back once. Any byte that differs from 0xFF after an erase, or from the source byte after a program, gives status 2'b10.
- R8: `busy` is high from the cycle after the request until `done`. `done` is a one-cycle pulse with status 2'b00 on success. `status` is 0 whenever `done` is low.
- R9: A request that arrives while `busy` is high is ignored. Every flash access of an operation stays in the bank chosen when the operation was accepted.
- R10: After reset, `busy`, `done`, `fl_we` and `fl_re` are low and `status` is 0. No flash access occurs while the block is idle.
- R11: `fl_we` and `fl_re` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Start pulse, sampled while idle |
| req_op | input | 1 | 0 = erase, 1 = program |
| req_bank | input | BANK_W | Bank to operate on |
| src_idx | output | ADDR_W | Offset of the requested source byte |
| src_byte | input | 8 | Source byte at `src_idx`, same cycle |
| fl_addr | output | BANK_W+ADDR_W | Flash address {bank, offset} |
| fl_wdata | output | 8 | Flash write data |
| fl_we | output | 1 | Flash write strobe, one access per cycle |
| fl_re | output | 1 | Flash read strobe |
| fl_rdata | input | 8 | Flash read data, valid in the read cycle |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | 00 ok, 01 timeout, 10 verify mismatch |

## Verification
The bench attacks several corner cases, each of which exposes a specific fault:
- **Command decoding.** A behavioural flash decodes the unlock sequence. It flags any write out of order, at a wrong key offset or closer than GAP cycles to the previous write. A sequencer with a swapped key or a missing gap would program nothing, or would raise the sequence-error count.
- **Read-pair accounting.** The flash toggles its status bit for a fixed number of reads, so the exact number of reads at the bank base is known. An off-by-one poll limit, or a completion test on a single read, changes that count.
- **Stuck device.** Forced timeouts in both operations must produce exactly POLL_LIMIT pairs, a single programmed byte and no readback.
- **Verify faults.** An injected weak cell must still give a full readback and status 10. A design that stopped early, or that ignored the compare, would show up in the read count or in the status.

// File: rtl/flsq_pkg.sv
package flsq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CMD,
        ST_GAP,
        ST_POLL_A,
        ST_POLL_B,
        ST_RST,
        ST_RGAP,
        ST_VERIFY,
        ST_DONE
    } flsq_state_e;

    localparam logic [1:0] RES_OK        = 2'b00;
    localparam logic [1:0] RES_TIMEOUT   = 2'b01;
    localparam logic [1:0] RES_BADVERIFY = 2'b10;

    localparam logic OP_ERASE   = 1'b0;
    localparam logic OP_PROGRAM = 1'b1;

    localparam logic [7:0] CODE_UNLK1     = 8'hAA;
    localparam logic [7:0] CODE_UNLK2     = 8'h55;
    localparam logic [7:0] CODE_ERASE_ARM = 8'h80;
    localparam logic [7:0] CODE_ERASE_GO  = 8'h30;
    localparam logic [7:0] CODE_PROG      = 8'hA0;
    localparam logic [7:0] CODE_RESET     = 8'hF0;

    localparam logic [11:0] KEY_A_FULL = 12'h555;
    localparam logic [11:0] KEY_B_FULL = 12'h2AA;

endpackage

// File: rtl/flsq_ctr.sv
module flsq_ctr #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (clr)
            q <= '0;
        else if (inc)
            q <= q + 1'b1;
    end

endmodule

// File: rtl/flsq_cmd_rom.sv
module flsq_cmd_rom
    import flsq_pkg::*;
#(
    parameter int ADDR_W = 13
) (
    input  logic              op,
    input  logic [2:0]        step,
    input  logic [ADDR_W-1:0] idx,
    input  logic [7:0]        src_byte,
    output logic [ADDR_W-1:0] off,
    output logic [7:0]        wdat,
    output logic              last
);

    localparam logic [ADDR_W-1:0] KEY_A = ADDR_W'(KEY_A_FULL);
    localparam logic [ADDR_W-1:0] KEY_B = ADDR_W'(KEY_B_FULL);

    always_comb begin
        off  = '0;
        wdat = 8'h00;
        last = 1'b0;
        case (step)
            3'd0: begin off = KEY_A; wdat = CODE_UNLK1; end
            3'd1: begin off = KEY_B; wdat = CODE_UNLK2; end
            3'd2: begin
                off  = KEY_A;
                wdat = (op == OP_PROGRAM) ? CODE_PROG : CODE_ERASE_ARM;
            end
            3'd3: begin
                if (op == OP_PROGRAM) begin
                    off  = idx;
                    wdat = src_byte;
                    last = 1'b1;
                end else begin
                    off  = KEY_A;
                    wdat = CODE_UNLK1;
                end
            end
            3'd4: begin off = KEY_B; wdat = CODE_UNLK2; end
            3'd5: begin off = '0; wdat = CODE_ERASE_GO; last = 1'b1; end
            default: begin off = '0; wdat = 8'h00; last = 1'b0; end
        endcase
    end

endmodule

// File: rtl/flsq_bank_seq.sv
module flsq_bank_seq
    import flsq_pkg::*;
#(
    parameter int ADDR_W     = 13,
    parameter int BANK_W     = 1,
    parameter int GAP        = 50,
    parameter int POLL_LIMIT = 1000000
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req,
    input  logic                     req_op,
    input  logic [BANK_W-1:0]        req_bank,
    output logic [ADDR_W-1:0]        src_idx,
    input  logic [7:0]               src_byte,
    output logic [BANK_W+ADDR_W-1:0] fl_addr,
    output logic [7:0]               fl_wdata,
    output logic                     fl_we,
    output logic                     fl_re,
    input  logic [7:0]               fl_rdata,
    output logic                     busy,
    output logic                     done,
    output logic [1:0]               status
);

    localparam int GAP_W  = $clog2(GAP + 1);
    localparam int POLL_W = $clog2(POLL_LIMIT + 1);
    localparam logic [ADDR_W-1:0] IDX_LAST = '1;

    flsq_state_e st, nxt;

    logic              op_q;
    logic [BANK_W-1:0] bank_q;
    logic [2:0]        step;
    logic [ADDR_W-1:0] idx;
    logic              last_q;
    logic [7:0]        first_rd;
    logic              timed_out;
    logic              bad;

    logic [ADDR_W-1:0] rom_off;
    logic [7:0]        rom_dat;
    logic              rom_last;
    logic [GAP_W-1:0]  gap_q;
    logic [POLL_W-1:0] poll_q;
    logic              gap_clr, gap_inc, poll_clr, poll_inc;
    logic              gap_end, poll_end, same, idx_end;
    logic [7:0]        exp_byte;

    flsq_cmd_rom #(.ADDR_W(ADDR_W)) u_rom (
        .op       (op_q),
        .step     (step),
        .idx      (idx),
        .src_byte (src_byte),
        .off      (rom_off),
        .wdat     (rom_dat),
        .last     (rom_last)
    );

    flsq_ctr #(.W(GAP_W)) u_gap_ctr (
        .clk (clk), .rst_n (rst_n), .clr (gap_clr), .inc (gap_inc), .q (gap_q)
    );

    flsq_ctr #(.W(POLL_W)) u_poll_ctr (
        .clk (clk), .rst_n (rst_n), .clr (poll_clr), .inc (poll_inc), .q (poll_q)
    );

    assign gap_end  = (gap_q == GAP_W'(GAP - 1));
    assign poll_end = (poll_q == POLL_W'(POLL_LIMIT - 1));
    assign same     = (fl_rdata == first_rd);
    assign idx_end  = (idx == IDX_LAST);
    assign exp_byte = (op_q == OP_PROGRAM) ? src_byte : 8'hFF;
    assign src_idx  = idx;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            st <= ST_IDLE;
        else
            st <= nxt;
    end

    // transitions
    always_comb begin
        nxt = st;
        unique case (st)
            ST_IDLE:   if (req) nxt = ST_CMD;
            ST_CMD:    nxt = ST_GAP;
            ST_GAP:    if (gap_end) nxt = last_q ? ST_POLL_A : ST_CMD;
            ST_POLL_A: nxt = ST_POLL_B;
            ST_POLL_B: begin
                if (same)
                    nxt = (op_q == OP_PROGRAM && !idx_end) ? ST_GAP : ST_RST;
                else if (poll_end)
                    nxt = ST_RST;
                else
                    nxt = ST_POLL_A;
            end
            ST_RST:    nxt = ST_RGAP;
            ST_RGAP:   if (gap_end) nxt = timed_out ? ST_DONE : ST_VERIFY;
            ST_VERIFY: if (idx_end) nxt = ST_DONE;
            ST_DONE:   nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    // outputs and counter controls
    always_comb begin
        fl_addr  = '0;
        fl_wdata = 8'h00;
        fl_we    = 1'b0;
        fl_re    = 1'b0;
        done     = 1'b0;
        status   = RES_OK;
        busy     = (st != ST_IDLE);
        gap_clr  = !(st == ST_GAP || st == ST_RGAP);
        gap_inc  = (st == ST_GAP || st == ST_RGAP);
        poll_clr = (st == ST_GAP || st == ST_IDLE);
        poll_inc = (st == ST_POLL_B) && !same;
        unique case (st)
            ST_CMD: begin
                fl_we    = 1'b1;
                fl_addr  = {bank_q, rom_off};
                fl_wdata = rom_dat;
            end
            ST_RST: begin
                fl_we    = 1'b1;
                fl_addr  = {bank_q, {ADDR_W{1'b0}}};
                fl_wdata = CODE_RESET;
            end
            ST_POLL_A, ST_POLL_B: begin
                fl_re   = 1'b1;
                fl_addr = {bank_q, {ADDR_W{1'b0}}};
            end
            ST_VERIFY: begin
                fl_re   = 1'b1;
                fl_addr = {bank_q, idx};
            end
            ST_DONE: begin
                done   = 1'b1;
                status = timed_out ? RES_TIMEOUT : (bad ? RES_BADVERIFY : RES_OK);
            end
            default: ;
        endcase
    end

    // operation context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q      <= OP_ERASE;
            bank_q    <= '0;
            step      <= '0;
            idx       <= '0;
            last_q    <= 1'b0;
            first_rd  <= 8'h00;
            timed_out <= 1'b0;
            bad       <= 1'b0;
        end else begin
            unique case (st)
                ST_IDLE: if (req) begin
                    op_q      <= req_op;
                    bank_q    <= req_bank;
                    step      <= '0;
                    idx       <= '0;
                    last_q    <= 1'b0;
                    timed_out <= 1'b0;
                    bad       <= 1'b0;
                end
                ST_CMD: begin
                    last_q <= rom_last;
                    step   <= rom_last ? 3'd0 : step + 3'd1;
                end
                ST_POLL_A: first_rd <= fl_rdata;
                ST_POLL_B: begin
                    if (same) begin
                        if (op_q == OP_PROGRAM && !idx_end) begin
                            idx    <= idx + 1'b1;
                            last_q <= 1'b0;
                        end
                    end else if (poll_end) begin
                        timed_out <= 1'b1;
                    end
                end
                ST_RGAP: if (gap_end) idx <= '0;
                ST_VERIFY: begin
                    if (fl_rdata != exp_byte) bad <= 1'b1;
                    if (!idx_end) idx <= idx + 1'b1;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/flsq_bank_seq_chk.sv
module flsq_bank_seq_chk #(
    parameter int ADDR_W = 13,
    parameter int BANK_W = 1,
    parameter int GAP    = 50
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     req,
    input logic [BANK_W-1:0]        req_bank,
    input logic [BANK_W+ADDR_W-1:0] fl_addr,
    input logic [7:0]               fl_wdata,
    input logic                     fl_we,
    input logic                     fl_re,
    input logic                     busy,
    input logic                     done,
    input logic [1:0]               status
);

    localparam int FA_W = BANK_W + ADDR_W;
    localparam int SW   = $clog2(GAP + 2);

    logic [SW-1:0]     since;
    logic [BANK_W-1:0] bank_seen;
    logic              rst_seen;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since     <= SW'(GAP);
            bank_seen <= '0;
            rst_seen  <= 1'b0;
        end else begin
            if (fl_we)
                since <= '0;
            else if (since < SW'(GAP))
                since <= since + 1'b1;
            if (!busy && req)
                bank_seen <= req_bank;
            if (done)
                rst_seen <= 1'b0;
            else if (fl_we && fl_wdata == 8'hF0 && fl_addr[ADDR_W-1:0] == '0)
                rst_seen <= 1'b1;
        end
    end

    // R11
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(fl_we && fl_re));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    // R8
    status_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> status == 2'b00);

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!fl_we && !fl_re));

    // R3
    write_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fl_we |-> since >= SW'(GAP));

    // R9
    bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_we || fl_re) |-> fl_addr[FA_W-1 -: BANK_W] == bank_seen);

    // R6
    reset_before_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> rst_seen);

endmodule

bind flsq_bank_seq flsq_bank_seq_chk #(
    .ADDR_W (ADDR_W),
    .BANK_W (BANK_W),
    .GAP    (GAP)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (req),
    .req_bank (req_bank),
    .fl_addr  (fl_addr),
    .fl_wdata (fl_wdata),
    .fl_we    (fl_we),
    .fl_re    (fl_re),
    .busy     (busy),
    .done     (done),
    .status   (status)
);

// File: tb/flsq_bank_seq_test.sv
module flsq_bank_seq_test;

    localparam int AW = 5;
    localparam int BW = 1;
    localparam int GP = 2;
    localparam int PL = 8;
    localparam int NB = 1 << AW;
    localparam int FW = AW + BW;
    localparam int ERS_BUSY = 3;
    localparam int PRG_BUSY = 2;
    localparam logic [AW-1:0] KA = 5'h15;
    localparam logic [AW-1:0] KB = 5'h0A;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic          rst_n, req, req_op;
    logic [BW-1:0] req_bank;
    logic [AW-1:0] src_idx;
    logic [7:0]    src_byte;
    logic [FW-1:0] fl_addr;
    logic [7:0]    fl_wdata, fl_rdata;
    logic          fl_we, fl_re, busy, done;
    logic [1:0]    status;

    int pat = 0;

    function automatic logic [7:0] pat_byte(input int p, input int i);
        return 8'(((i * 29) + (p * 83) + 17) ^ (p * 16));
    endfunction

    assign src_byte = pat_byte(pat, int'(src_idx));

    flsq_bank_seq #(.ADDR_W(AW), .BANK_W(BW), .GAP(GP), .POLL_LIMIT(PL)) uut (
        .clk (clk), .rst_n (rst_n), .req (req), .req_op (req_op), .req_bank (req_bank),
        .src_idx (src_idx), .src_byte (src_byte), .fl_addr (fl_addr), .fl_wdata (fl_wdata),
        .fl_we (fl_we), .fl_re (fl_re), .fl_rdata (fl_rdata), .busy (busy), .done (done),
        .status (status)
    );

    // behavioural flash
    logic [7:0] mem [0:2*NB-1];
    int  bsy = 0;
    logic tog = 1'b0;
    bit  stuck = 0, ers_weak = 0, prg_weak = 0;
    int  exp_bank = 0;
    int  seq = 0, cyc = 0, last_wr = 0;
    bit  have_wr = 0;
    int  seq_err = 0, gap_err = 0, wrong_bank = 0, rst_cnt = 0;
    int  ers_cnt = 0, prg_cnt = 0, base_rd = 0, nb_rd = 0;

    assign fl_rdata = (bsy > 0 || stuck) ? {1'b0, tog, 6'b0} : mem[fl_addr];

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst_n) begin
            for (int j = 0; j < 2 * NB; j++) mem[j] <= 8'h00;
            bsy <= 0; tog <= 1'b0; seq <= 0; have_wr <= 0;
        end else begin
            if (fl_re) begin
                if (bsy > 0 || stuck) begin
                    tog <= ~tog;
                    if (bsy > 0) bsy <= bsy - 1;
                end
                if (fl_addr[AW-1:0] == '0) base_rd <= base_rd + 1;
                else nb_rd <= nb_rd + 1;
                if (int'(fl_addr[FW-1]) != exp_bank) wrong_bank <= wrong_bank + 1;
            end
            if (fl_we) begin
                if (have_wr && (cyc - last_wr) <= GP) gap_err <= gap_err + 1;
                have_wr <= 1;
                last_wr <= cyc;
                if (int'(fl_addr[FW-1]) != exp_bank) wrong_bank <= wrong_bank + 1;
                if (fl_wdata == 8'hF0 && fl_addr[AW-1:0] == '0) begin
                    rst_cnt <= rst_cnt + 1;
                    seq <= 0;
                end else begin
                    case (seq)
                        0: if (fl_addr[AW-1:0] == KA && fl_wdata == 8'hAA) seq <= 1;
                           else begin seq_err <= seq_err + 1; seq <= 0; end
                        1: if (fl_addr[AW-1:0] == KB && fl_wdata == 8'h55) seq <= 2;
                           else begin seq_err <= seq_err + 1; seq <= 0; end
                        2: if (fl_addr[AW-1:0] == KA && fl_wdata == 8'h80) seq <= 3;
                           else if (fl_addr[AW-1:0] == KA && fl_wdata == 8'hA0) seq <= 6;
                           else begin seq_err <= seq_err + 1; seq <= 0; end
                        3: if (fl_addr[AW-1:0] == KA && fl_wdata == 8'hAA) seq <= 4;
                           else begin seq_err <= seq_err + 1; seq <= 0; end
                        4: if (fl_addr[AW-1:0] == KB && fl_wdata == 8'h55) seq <= 5;
                           else begin seq_err <= seq_err + 1; seq <= 0; end
                        5: begin
                            if (fl_addr[AW-1:0] == '0 && fl_wdata == 8'h30) begin
                                for (int j = 0; j < NB; j++)
                                    mem[int'(fl_addr[FW-1]) * NB + j] <= (ers_weak && j == 7) ? 8'hFB : 8'hFF;
                                bsy <= ERS_BUSY;
                                ers_cnt <= ers_cnt + 1;
                            end else seq_err <= seq_err + 1;
                            seq <= 0;
                        end
                        6: begin
                            mem[fl_addr] <= (mem[fl_addr] & fl_wdata) ^ (prg_weak ? 8'h10 : 8'h00);
                            bsy <= PRG_BUSY;
                            prg_cnt <= prg_cnt + 1;
                            seq <= 0;
                        end
                        default: begin seq_err <= seq_err + 1; seq <= 0; end
                    endcase
                end
            end
        end
    end

    // checking
    int total = 0, bad = 0;
    logic [1:0] got_st;
    int d_seq, d_gap, d_wb, d_rst, d_ers, d_prg, d_base, d_nb;
    logic [7:0] keep [0:NB-1];

    task automatic finish_up();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    task automatic run_op(input bit op, input int bk, input bit poke);
        int s_seq, s_gap, s_wb, s_rst, s_ers, s_prg, s_base, s_nb;
        int n;
        exp_bank = bk;
        s_seq = seq_err; s_gap = gap_err; s_wb = wrong_bank; s_rst = rst_cnt;
        s_ers = ers_cnt; s_prg = prg_cnt; s_base = base_rd; s_nb = nb_rd;
        @(negedge clk);
        req = 1'b1; req_op = op; req_bank = BW'(bk);
        @(negedge clk);
        req = 1'b0;
        chk(busy == 1'b1, "R8 busy after request", int'(busy), 1);
        n = 0;
        while (!done && n < 20000) begin
            if (poke && n == 10) begin
                req = 1'b1; req_op = ~op; req_bank = ~BW'(bk);
            end else req = 1'b0;
            @(negedge clk);
            n++;
        end
        req = 1'b0;
        if (!done) begin
            total++; bad++;
            $display("FAIL R8 watchdog actual=no_done expected=done");
            finish_up();
        end
        got_st = status;
        d_seq = seq_err - s_seq; d_gap = gap_err - s_gap; d_wb = wrong_bank - s_wb;
        d_rst = rst_cnt - s_rst; d_ers = ers_cnt - s_ers; d_prg = prg_cnt - s_prg;
        d_base = base_rd - s_base; d_nb = nb_rd - s_nb;
        @(negedge clk);
    endtask

    task automatic snap_other(input int bk);
        for (int j = 0; j < NB; j++) keep[j] = mem[(1 - bk) * NB + j];
    endtask

    task automatic check_other(input int bk, input string rq);
        int mis = 0;
        for (int j = 0; j < NB; j++) if (mem[(1 - bk) * NB + j] != keep[j]) mis++;
        chk(mis == 0, rq, mis, 0);
    endtask

    task automatic check_bank(input int bk, input bit erased, input int p, input string rq);
        int mis = 0;
        for (int j = 0; j < NB; j++)
            if (mem[bk * NB + j] != (erased ? 8'hFF : pat_byte(p, j))) mis++;
        chk(mis == 0, rq, mis, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL R8 global watchdog actual=hung expected=finished");
        finish_up();
    end

    initial begin
        rst_n = 1'b0; req = 1'b0; req_op = 1'b0; req_bank = '0;
        repeat (3) @(negedge clk);
        chk(!busy && !done && !fl_we && !fl_re && status == 2'b00, "R10 in reset",
            int'({busy, done, fl_we, fl_re}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!busy && !done && !fl_we && !fl_re && status == 2'b00, "R10 after reset",
            int'({busy, done, fl_we, fl_re}), 0);

        for (int bk = 0; bk < 2; bk++) begin
            for (int p = 0; p < 3; p++) begin
                snap_other(bk);
                run_op(1'b0, bk, 1'b0);
                chk(got_st == 2'b00, "R8 erase status ok", int'(got_st), 0);
                chk(d_ers == 1 && d_seq == 0, "R1 erase sequence", d_seq, 0);
                chk(d_gap == 0, "R3 erase gaps", d_gap, 0);
                chk(d_rst == 1, "R6 erase reset write", d_rst, 1);
                chk(d_base == 2 * ERS_BUSY + 1, "R4 erase poll reads", d_base, 2 * ERS_BUSY + 1);
                chk(d_nb == NB - 1, "R7 erase readback", d_nb, NB - 1);
                check_bank(bk, 1'b1, 0, "R1 bank erased");
                check_other(bk, "R1 other bank untouched");

                pat = p;
                run_op(1'b1, bk, 1'b0);
                chk(got_st == 2'b00, "R8 program status ok", int'(got_st), 0);
                chk(d_prg == NB && d_seq == 0, "R2 program sequence", d_prg, NB);
                chk(d_gap == 0, "R3 program gaps", d_gap, 0);
                chk(d_rst == 1, "R6 program reset write", d_rst, 1);
                chk(d_base == 4 * NB + 1, "R4 program poll reads", d_base, 4 * NB + 1);
                chk(d_wb == 0, "R9 program bank", d_wb, 0);
                check_bank(bk, 1'b0, p, "R2 bank data");
                check_other(bk, "R2 other bank untouched");
            end
        end

        // R5 erase timeout
        stuck = 1;
        run_op(1'b0, 1, 1'b0);
        stuck = 0;
        chk(got_st == 2'b01, "R5 erase timeout status", int'(got_st), 1);
        chk(d_base == 2 * PL, "R5 erase poll pairs", d_base, 2 * PL);
        chk(d_nb == 0, "R5 no readback", d_nb, 0);
        chk(d_rst == 1, "R6 reset after timeout", d_rst, 1);

        // R5 program timeout aborts
        stuck = 1;
        run_op(1'b1, 0, 1'b0);
        stuck = 0;
        chk(got_st == 2'b01, "R5 program timeout status", int'(got_st), 1);
        chk(d_prg == 1, "R5 program abort", d_prg, 1);
        chk(d_base == 2 * PL, "R5 program poll pairs", d_base, 2 * PL);
        chk(d_nb == 0, "R5 program no readback", d_nb, 0);

        // R7 erase verify failure
        ers_weak = 1;
        run_op(1'b0, 0, 1'b0);
        ers_weak = 0;
        chk(got_st == 2'b10, "R7 erase mismatch status", int'(got_st), 2);
        chk(d_nb == NB - 1, "R7 full readback on mismatch", d_nb, NB - 1);

        // R7 program verify failure
        run_op(1'b0, 1, 1'b0);
        chk(got_st == 2'b00, "R7 erase before weak program", int'(got_st), 0);
        prg_weak = 1; pat = 1;
        run_op(1'b1, 1, 1'b0);
        prg_weak = 0;
        chk(got_st == 2'b10, "R7 program mismatch status", int'(got_st), 2);
        chk(d_prg == NB, "R7 no abort on mismatch", d_prg, NB);
        chk(d_nb == NB - 1, "R7 program full readback", d_nb, NB - 1);

        // R9 request while busy ignored
        run_op(1'b0, 0, 1'b0);
        pat = 2;
        snap_other(0);
        run_op(1'b1, 0, 1'b1);
        chk(got_st == 2'b00, "R9 status with stray request", int'(got_st), 0);
        chk(d_wb == 0, "R9 no access to other bank", d_wb, 0);
        chk(d_ers == 0, "R9 no erase started", d_ers, 0);
        check_bank(0, 1'b0, 2, "R9 data intact");
        check_other(0, "R9 other bank untouched");
        begin
            int hi = 0;
            for (int k = 0; k < 5; k++) begin
                @(negedge clk);
                if (busy) hi++;
            end
            chk(hi == 0, "R9 no second operation", hi, 0);
        end

        finish_up();
    end

endmodule